// File: doc/BRIEF.md
# Triggered timestamp capture unit

This block holds a free-running 16-bit timer and a bank of general registers. Each general register can be armed to take a snapshot of the timer when a pulse arrives from a compare-match of its own event-counter channel. Software can compare two successive snapshots to get the time between event-count cycles. Software, or the counter channel's own logic, uses the single-cycle trigger pulses. Software sets up the unit through a small register port. That port holds the start bit, a per-register source select, an interrupt-enable mask, write-1-to-clear capture flags, the timer itself and the general registers.

All state is synchronous to one clock, and the reset is active high. Reads are registered: the data for the address presented in a cycle appears on the read bus after the next rising edge. The address bus is shared by reads and writes.

Top module: `stamp_capture_unit`

## Requirements
- R1: After reset the timer, the start bit, the source selects, the enables, the flags, every general register, the read bus and the interrupt are all zero.
- R2: While the start bit (address 0, bit 0) is 1, the timer (address 4) rises by one every clock and wraps from 0xFFFF to 0x0000. While the start bit is 0 it holds. A software write to address 4 loads the timer and takes precedence over counting.
- R3: Trigger input bit i (bit 0 = register A through bit 3 = register D) acts only on general register i (addresses 8 + i) and on capture flag bit i.
- R4: Source-select bit i (address 1) set to 1 selects the event-counter trigger for register i. While it is 0, a trigger pulse leaves register i and flag i unchanged.
- R5: No capture takes place while the start bit is 0.
- R6: A capture loads register i with the timer value present in the cycle the pulse arrives, before that cycle's increment.
- R7: A capture sets flag bit i (address 3, also visible on the flag output). Writing 1 to a flag bit clears it, and writing 0 leaves it. A capture in the same cycle as a clear leaves the flag set.
- R8: The interrupt output is high whenever any flag bit is 1 and its enable bit (address 2) is 1.
- R9: Software can write a general register. When a capture lands on it in the same cycle, the captured value wins.
- R10: A read returns the addressed register one clock later. Addresses with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 4 | Compare-match pulses from event counters A..D |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for read and write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| cap_flag_o | output | 4 | Capture flags A..D |
| irq_o | output | 1 | Interrupt request |

## Verification
If the timer state goes wrong, a read of address 4 shows it one clock later, and so does the next snapshot of any armed register. If a source select, the start bit or a slot mapping goes wrong, the fault sits hidden until a pulse arrives. It then shows on the flag output in the very next cycle, and in the register value on the first read after that. The bench model follows every register and compares the read bus, the flags and the interrupt on every clock. A divergence is therefore reported at most one cycle after it becomes observable.

// File: rtl/stc_pkg.sv
package stc_pkg;
  // register port map
  localparam int ADR_CTRL  = 0;  // bit 0: timer run
  localparam int ADR_SEL   = 1;  // bit i: trigger source for slot i
  localparam int ADR_IEN   = 2;  // bit i: interrupt enable for slot i
  localparam int ADR_FLAG  = 3;  // bit i: capture flag, write 1 to clear
  localparam int ADR_CNT   = 4;  // timer value
  localparam int ADR_GR0   = 8;  // first general register
endpackage

// File: rtl/stc_timebase.sv
module stc_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stc_slot.sv
module stc_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trig,
  input  logic         sel,
  input  logic         run,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] gr,
  output logic         flag
);
  logic cap;
  assign cap = trig & sel & run;

  always_ff @(posedge clk) begin
    if (rst) begin
      gr   <= '0;
      flag <= 1'b0;
    end else begin
      if (cap)     gr <= cnt;
      else if (wr) gr <= wdata;
      if (cap)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/stamp_capture_unit.sv
module stamp_capture_unit #(
  parameter int W      = 16,
  parameter int N      = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      trig_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [W-1:0]      reg_wdata_i,
  output logic [W-1:0]      reg_rdata_o,
  output logic [N-1:0]      cap_flag_o,
  output logic              irq_o
);
  import stc_pkg::*;

  logic                run_q;
  logic [N-1:0]        sel_q;
  logic [N-1:0]        ien_q;
  logic [N-1:0]        flag_q;
  logic [W-1:0]        cnt_q;
  logic [N-1:0][W-1:0] gr_q;
  logic                cnt_ld;

  assign cnt_ld = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      sel_q <= '0;
      ien_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_W'(ADR_CTRL)) run_q <= reg_wdata_i[0];
      if (reg_addr_i == ADDR_W'(ADR_SEL))  sel_q <= reg_wdata_i[N-1:0];
      if (reg_addr_i == ADDR_W'(ADR_IEN))  ien_q <= reg_wdata_i[N-1:0];
    end
  end

  stc_timebase #(.W(W)) u_tb (
    .clk(clk), .rst(rst), .run(run_q), .load(cnt_ld),
    .load_val(reg_wdata_i), .cnt(cnt_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic gr_wr, fl_clr;
    assign gr_wr  = reg_we_i && (reg_addr_i == ADDR_W'(ADR_GR0 + i));
    assign fl_clr = reg_we_i && (reg_addr_i == ADDR_W'(ADR_FLAG)) && reg_wdata_i[i];
    stc_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst), .trig(trig_i[i]), .sel(sel_q[i]), .run(run_q),
      .wr(gr_wr), .wdata(reg_wdata_i), .clr(fl_clr), .cnt(cnt_q),
      .gr(gr_q[i]), .flag(flag_q[i])
    );
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      ADDR_W'(ADR_CTRL): rd_mux = W'(run_q);
      ADDR_W'(ADR_SEL):  rd_mux = W'(sel_q);
      ADDR_W'(ADR_IEN):  rd_mux = W'(ien_q);
      ADDR_W'(ADR_FLAG): rd_mux = W'(flag_q);
      ADDR_W'(ADR_CNT):  rd_mux = cnt_q;
      default: ;
    endcase
    for (int k = 0; k < N; k++)
      if (reg_addr_i == ADDR_W'(ADR_GR0 + k)) rd_mux = gr_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_mux;
  end

  assign cap_flag_o = flag_q;
  assign irq_o      = |(flag_q & ien_q);
endmodule

// File: rtl/stc_capture_chk.sv
module stc_capture_chk #(
  parameter int W      = 16,
  parameter int N      = 4,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [N-1:0]        trig,
  input logic                we,
  input logic [ADDR_W-1:0]   addr,
  input logic [W-1:0]        wdata,
  input logic                run,
  input logic [N-1:0]        sel,
  input logic [W-1:0]        cnt,
  input logic [N-1:0][W-1:0] gr,
  input logic [N-1:0]        flag
);
  import stc_pkg::*;

  logic cnt_wr;
  assign cnt_wr = we && (addr == ADDR_W'(ADR_CNT));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    run && !cnt_wr |=> cnt == W'($past(cnt) + 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run && !cnt_wr |=> $stable(cnt));

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic gwr, fclr;
    assign gwr  = we && (addr == ADDR_W'(ADR_GR0 + i));
    assign fclr = we && (addr == ADDR_W'(ADR_FLAG)) && wdata[i];

    // R6
    snap_value_chk: assert property (@(posedge clk) disable iff (rst)
      trig[i] && sel[i] && run |=> gr[i] == $past(cnt));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      trig[i] && sel[i] && run |=> flag[i]);

    // R4
    unsel_gr_chk: assert property (@(posedge clk) disable iff (rst)
      trig[i] && !sel[i] && !gwr |=> $stable(gr[i]));

    // R4
    unsel_flag_chk: assert property (@(posedge clk) disable iff (rst)
      trig[i] && !sel[i] && !fclr |=> $stable(flag[i]));

    // R5
    stopped_chk: assert property (@(posedge clk) disable iff (rst)
      !run && !gwr |=> $stable(gr[i]));
  end
endmodule

bind stamp_capture_unit stc_capture_chk #(.W(W), .N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig_i), .we(reg_we_i), .addr(reg_addr_i),
  .wdata(reg_wdata_i), .run(run_q), .sel(sel_q), .cnt(cnt_q), .gr(gr_q),
  .flag(flag_q)
);

// File: tb/test_stamp_capture_unit.sv
`timescale 1ns/1ps
module test_stamp_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  trig = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  flags;
  logic        irq;

  always #2.5 clk = ~clk;

  stamp_capture_unit i_stamp_capture_unit (
    .clk(clk), .rst(rst), .trig_i(trig), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cap_flag_o(flags), .irq_o(irq)
  );

  int tests = 0, fails = 0;
  string req = "R1";

  // behavioural reference state
  int m_cnt, m_run, m_sel, m_ien, m_flag, m_rd;
  int m_gr[4];

  function automatic int mread(int a);
    case (a)
      0: return m_run;
      1: return m_sel;
      2: return m_ien;
      3: return m_flag;
      4: return m_cnt;
      8, 9, 10, 11: return m_gr[a-8];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // called at a falling edge: compare, drive, advance model, wait one clock
  task automatic step(bit w, int a, int d, int t);
    int n_cnt, n_flag;
    int n_gr[4];
    chk("read bus (R10)", int'(rdata), m_rd);
    chk("flags (R7)", int'(flags), m_flag);
    chk("irq (R8)", int'(irq), ((m_flag & m_ien) != 0) ? 1 : 0);
    we = w; addr = 4'(a); wdata = 16'(d); trig = 4'(t);
    m_rd = mread(a);
    n_cnt = m_cnt; n_flag = m_flag;
    for (int i = 0; i < 4; i++) n_gr[i] = m_gr[i];
    if (w && a == 4) n_cnt = d & 16'hFFFF;
    else if (m_run != 0) n_cnt = (m_cnt + 1) & 16'hFFFF;
    for (int i = 0; i < 4; i++) begin
      bit cap = t[i] && m_sel[i] && (m_run != 0);
      if (cap) begin n_gr[i] = m_cnt; n_flag |= (1 << i); end
      else begin
        if (w && a == 8 + i) n_gr[i] = d & 16'hFFFF;
        if (w && a == 3 && d[i]) n_flag &= ~(1 << i);
      end
    end
    if (w && a == 0) m_run = d & 1;
    if (w && a == 1) m_sel = d & 15;
    if (w && a == 2) m_ien = d & 15;
    m_cnt = n_cnt; m_flag = n_flag;
    for (int i = 0; i < 4; i++) m_gr[i] = n_gr[i];
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(int n, int a);
    for (int k = 0; k < n; k++) step(0, a, 0, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before the end of all requirement checks");
    summary();
  end

  initial begin
    m_cnt = 0; m_run = 0; m_sel = 0; m_ien = 0; m_flag = 0; m_rd = 0;
    for (int i = 0; i < 4; i++) m_gr[i] = 0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state through every address
    req = "R1";
    for (int a = 0; a < 16; a++) step(0, a, 0, 0);
    // R2: counting, holding, load and wrap
    req = "R2";
    step(1, 0, 1, 0);
    idle(6, 4);
    step(1, 4, 16'hFFFD, 0);
    idle(5, 4);
    step(1, 0, 0, 0);
    idle(4, 4);
    step(1, 0, 1, 0);
    // R3 and R6: each trigger alone, readback of all registers
    req = "R3";
    step(1, 1, 15, 0);
    for (int i = 0; i < 4; i++) begin
      idle(3, 0);
      step(0, 4, 0, 1 << i);
      for (int a = 8; a < 12; a++) step(0, a, 0, 0);
    end
    req = "R6";
    step(0, 4, 0, 15);
    for (int a = 8; a < 12; a++) step(0, a, 0, 0);
    // R7: clear, and clear colliding with capture
    req = "R7";
    step(1, 3, 5, 0);
    step(0, 3, 0, 0);
    step(1, 3, 15, 2);
    step(0, 3, 0, 0);
    step(1, 3, 15, 0);
    // R4: unselected sources ignore pulses
    req = "R4";
    step(1, 1, 5, 0);
    step(0, 3, 0, 15);
    for (int a = 8; a < 12; a++) step(0, a, 0, 0);
    step(0, 3, 0, 0);
    // R5: stopped timer blocks capture
    req = "R5";
    step(1, 1, 15, 0);
    step(1, 3, 15, 0);
    step(1, 0, 0, 0);
    step(0, 3, 0, 15);
    for (int a = 8; a < 12; a++) step(0, a, 0, 0);
    step(1, 0, 1, 0);
    // R8: interrupt masking
    req = "R8";
    step(1, 2, 4, 0);
    step(0, 0, 0, 1);
    idle(2, 2);
    step(0, 0, 0, 4);
    idle(2, 2);
    step(1, 3, 4, 0);
    idle(2, 3);
    // R9: software write and collision with capture
    req = "R9";
    step(1, 9, 16'hBEEF, 0);
    step(0, 9, 0, 0);
    step(1, 9, 16'h1234, 2);
    step(0, 9, 0, 0);
    // R10: unmapped addresses read zero
    req = "R10";
    for (int a = 5; a < 8; a++) step(0, a, 0, 0);
    for (int a = 12; a < 16; a++) step(0, a, 0, 0);
    // mixed random traffic under the full model
    req = "R3/R4/R9 random";
    for (int k = 0; k < 3000; k++) begin
      int a = $urandom_range(0, 15);
      bit w = ($urandom_range(0, 3) == 0) && (a != 0 || $urandom_range(0, 3) == 0);
      int d = $urandom_range(0, 16'hFFFF);
      if (a == 0) d = d | 1;
      step(w, a, d, $urandom_range(0, 15));
    end
    idle(2, 0);
    summary();
  end
endmodule